// File: doc/BRIEF.md
# Synthesizer Divider Chain and Test Observation Mux

This block holds the digital dividers of a clock synthesizer and the selector that feeds its single test pin. A reference prescaler produces the phase-comparison reference. A feedback divider produces the phase-comparison feedback. An output divider produces the synthesized clock. The loop filter, the phase comparison and the oscillator itself live elsewhere. The oscillator appears here only as an input.

The block runs on one system clock. Each source clock is presented as a strobe input. One strobe marks one half-period of that source, that is, one edge of it. Rising edges are the odd-numbered strobes after reset: the 1st, the 3rd, and so on. The divided outputs are registered levels. A level that toggles every K strobes therefore has a period of K source periods.

The feedback divider counts M oscillator rising edges, then flips a toggle stage, which gives an overall division of 2M. The output divider divides by 1, 2, 4 or 8, selected by a code, and keeps a 50% duty cycle. A new M or N value is sampled only on the divider's terminal count, so a change never truncates a cycle already in progress. An output enable gates the synthesized clock. The test selector can expose any of eight internal signals. In one of its settings it moves the feedback divider's clock source over to the serial-clock strobe.

Top module: `synth_divchain`

## Requirements
- R1: While reset is asserted, and for the cycles up to the first source strobe after it, `ref_div`, `fb_div` and `fout` are low.
- R2: `ref_div` toggles once every 16 `ref_edge` strobes (divide by 16 of the reference) and holds its value in cycles without a `ref_edge`.
- R3: `fb_div` toggles once every M rising edges of its source, which is every 2·M source strobes, M being `m_cfg`. Valid M runs from 100 to 350.
- R4: `fout` toggles every N `vco_edge` strobes, where `n_cfg` 2'b00 gives N=2, 2'b01 gives N=4, 2'b10 gives N=8 and 2'b11 gives N=1.
- R5: `fout` has equal high and low times, in strobes, for every `n_cfg` code.
- R6: A change of `m_cfg` during a feedback count leaves the current interval at the old M. The new M governs from the next terminal count onward.
- R7: A change of `n_cfg` during an output count leaves the current half-period at the old N. The new N governs from the next terminal count onward.
- R8: When `oe` is low, `fout` stays low while the output divider keeps counting. When `oe` returns high, toggling resumes at interval N.
- R9: `test_out` follows `sr_out` when `test_sel` = 3'b000. It is constant high for 3'b001 and constant low for 3'b101.
- R10: `test_out` shows `ref_div` for `test_sel` = 3'b010, `fb_div` for 3'b011 and `fout` for 3'b100.
- R11: With `test_sel` = 3'b110, the feedback divider counts `sclk_edge` strobes instead of `vco_edge` strobes, and `test_out` shows `fb_div`.
- R12: With `test_sel` = 3'b111, `test_out` is the output-divider clock divided by 4, toggling every 4·N `vco_edge` strobes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_edge | input | 1 | One half-period of the reference clock |
| vco_edge | input | 1 | One half-period of the oscillator clock |
| sclk_edge | input | 1 | One half-period of the serial clock |
| m_cfg | input | 9 | Feedback divide value M |
| n_cfg | input | 2 | Output divide code |
| test_sel | input | 3 | Test pin source select |
| oe | input | 1 | Output enable for `fout` |
| sr_out | input | 1 | Serial output of the configuration shift register |
| ref_div | output | 1 | Prescaled reference for phase comparison |
| fb_div | output | 1 | Feedback clock for phase comparison |
| fout | output | 1 | Synthesized output clock |
| test_out | output | 1 | Test pin |

## Verification
Two events can coincide in one cycle: a reconfiguration write and the terminal count that reloads the same counter. The bench provokes this by changing `m_cfg` or `n_cfg` a fixed number of cycles after an observed toggle. It then judges the remaining part of the running interval against the old value and the interval after it against the new value. A second coincidence arises when the test select moves the feedback counter from oscillator strobes to serial strobes in the middle of a count. The bench checks that `fb_div` freezes while only oscillator strobes arrive, and that it resumes at 2·M once serial strobes appear.

// File: rtl/synth_divchain_pkg.sv
package synth_divchain_pkg;

  localparam int N_W = 4;

  typedef enum logic [2:0] {
    TS_SHIFT   = 3'b000,
    TS_HIGH    = 3'b001,
    TS_REF     = 3'b010,
    TS_FB      = 3'b011,
    TS_OUT     = 3'b100,
    TS_LOW     = 3'b101,
    TS_FB_SER  = 3'b110,
    TS_OUT_Q   = 3'b111
  } test_sel_e;

  // Output divider code to divide value (non-monotonic mapping).
  function automatic logic [N_W-1:0] n_ratio(input logic [1:0] code);
    case (code)
      2'b00:   return N_W'(2);
      2'b01:   return N_W'(4);
      2'b10:   return N_W'(8);
      default: return N_W'(1);
    endcase
  endfunction

endpackage

// File: rtl/sdc_ref_prescale.sv
module sdc_ref_prescale #(
  parameter int PRE_DIV = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic step,
  output logic div_q
);
  localparam int CW = (PRE_DIV > 1) ? $clog2(PRE_DIV) : 1;
  localparam logic [CW-1:0] LAST = CW'(PRE_DIV - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          div_d;

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    if (step) begin
      if (cnt_q == LAST) begin
        cnt_d = '0;
        div_d = ~div_q;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
    end else if (step) begin
      cnt_q <= cnt_d;
      div_q <= div_d;
    end
  end

  // R2: output only moves on a reference strobe
  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(div_q));

endmodule

// File: rtl/sdc_fb_divider.sv
module sdc_fb_divider #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           step,
  input  logic [M_W-1:0] m_val,
  output logic           fb_q
);
  localparam logic [M_W-1:0] ONE = M_W'(1);

  logic           phase_q, phase_d;
  logic [M_W-1:0] cnt_q, cnt_d;
  logic           fb_d;
  logic           rise;
  logic           tc;

  assign rise = step & ~phase_q;
  assign tc   = rise & (cnt_q == '0);

  always_comb begin
    phase_d = phase_q;
    cnt_d   = cnt_q;
    fb_d    = fb_q;
    if (step) phase_d = ~phase_q;
    if (rise) cnt_d = tc ? (m_val - ONE) : (cnt_q - ONE);
    if (tc)   fb_d  = ~fb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= 1'b0;
      cnt_q   <= '0;
      fb_q    <= 1'b0;
    end else if (step) begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
      fb_q    <= fb_d;
    end
  end

  // R3: toggle stage flips only on a terminal count
  a_r3_toggle_only_on_tc: assert property (@(posedge clk) disable iff (!rst_n)
    !tc |=> $stable(fb_q));

  // R6: mid-count rising edges decrement and never reload
  a_r6_no_midcount_reload: assert property (@(posedge clk) disable iff (!rst_n)
    (rise && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - ONE));

endmodule

// File: rtl/sdc_out_divider.sv
module sdc_out_divider
  import synth_divchain_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       step,
  input  logic [1:0] n_code,
  output logic       div_q,
  output logic       quart_q
);
  localparam logic [N_W-1:0] ONE = N_W'(1);

  logic [N_W-1:0] cnt_q, cnt_d;
  logic           div_d;
  logic [1:0]     qc_q, qc_d;
  logic           tc;

  assign tc = step & (cnt_q == '0);

  always_comb begin
    cnt_d = cnt_q;
    div_d = div_q;
    qc_d  = qc_q;
    if (step) cnt_d = tc ? (n_ratio(n_code) - ONE) : (cnt_q - ONE);
    if (tc) begin
      div_d = ~div_q;
      if (!div_q) qc_d = qc_q + 2'd1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      div_q <= 1'b0;
      qc_q  <= 2'd0;
    end else if (step) begin
      cnt_q <= cnt_d;
      div_q <= div_d;
      qc_q  <= qc_d;
    end
  end

  assign quart_q = qc_q[1];

  // R4: divided clock moves only on an oscillator strobe
  a_r4_hold_without_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> $stable(div_q));

  // R12: quarter clock changes only together with a rising divided clock
  a_r12_quarter_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    !$rose(div_q) |-> $stable(quart_q));

endmodule

// File: rtl/synth_divchain.sv
module synth_divchain
  import synth_divchain_pkg::*;
#(
  parameter int PRE_DIV = 16,
  parameter int M_W     = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           ref_edge,
  input  logic           vco_edge,
  input  logic           sclk_edge,
  input  logic [M_W-1:0] m_cfg,
  input  logic [1:0]     n_cfg,
  input  logic [2:0]     test_sel,
  input  logic           oe,
  input  logic           sr_out,
  output logic           ref_div,
  output logic           fb_div,
  output logic           fout,
  output logic           test_out
);
  logic [1:0] rs_q;
  logic       rst_ni;
  logic       fb_step;
  logic       odiv;
  logic       oquart;
  test_sel_e  sel;

  // Asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_ni = rs_q[1];

  assign sel     = test_sel_e'(test_sel);
  assign fb_step = (sel == TS_FB_SER) ? sclk_edge : vco_edge;

  sdc_ref_prescale #(.PRE_DIV(PRE_DIV)) u_pre (
    .clk   (clk),
    .rst_n (rst_ni),
    .step  (ref_edge),
    .div_q (ref_div)
  );

  sdc_fb_divider #(.M_W(M_W)) u_fb (
    .clk   (clk),
    .rst_n (rst_ni),
    .step  (fb_step),
    .m_val (m_cfg),
    .fb_q  (fb_div)
  );

  sdc_out_divider u_out (
    .clk     (clk),
    .rst_n   (rst_ni),
    .step    (vco_edge),
    .n_code  (n_cfg),
    .div_q   (odiv),
    .quart_q (oquart)
  );

  assign fout = odiv & oe;

  always_comb begin
    case (sel)
      TS_SHIFT:  test_out = sr_out;
      TS_HIGH:   test_out = 1'b1;
      TS_REF:    test_out = ref_div;
      TS_FB:     test_out = fb_div;
      TS_OUT:    test_out = fout;
      TS_LOW:    test_out = 1'b0;
      TS_FB_SER: test_out = fb_div;
      TS_OUT_Q:  test_out = oquart;
      default:   test_out = 1'b0;
    endcase
  end

  // R8: with the enable low the synthesized clock never rises
  a_r8_gated_low: assert property (@(posedge clk) disable iff (!rst_ni)
    (!oe && !$past(oe)) |-> !$rose(fout));

endmodule

// File: tb/synth_divchain_tb_top.sv
`timescale 1ns/1ps
module synth_divchain_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       ref_edge, vco_edge, sclk_edge, oe, sr_out;
  logic [8:0] m_cfg;
  logic [1:0] n_cfg;
  logic [2:0] test_sel;
  logic       ref_div, fb_div, fout, test_out;
  int         n_run = 0;
  int         n_fail = 0;
  bit         done = 0;

  always #4 clk = ~clk;

  synth_divchain dut_i (
    .clk(clk), .rst_n(rst_n), .ref_edge(ref_edge), .vco_edge(vco_edge),
    .sclk_edge(sclk_edge), .m_cfg(m_cfg), .n_cfg(n_cfg), .test_sel(test_sel),
    .oe(oe), .sr_out(sr_out), .ref_div(ref_div), .fb_div(fb_div),
    .fout(fout), .test_out(test_out)
  );

  function automatic logic pick(input int s);
    case (s)
      0:       return ref_div;
      1:       return fb_div;
      2:       return fout;
      default: return test_out;
    endcase
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Cycles until the selected output changes (capped at lim).
  task automatic gap(input int s, input int lim, output int n);
    logic v;
    v = pick(s);
    n = 0;
    while (n < lim) begin
      @(negedge clk);
      n++;
      if (pick(s) != v) break;
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0; ref_edge = 0; vco_edge = 0; sclk_edge = 0;
    oe = 1; sr_out = 0; m_cfg = 9'd100; n_cfg = 2'b00; test_sel = 3'b101;
    repeat (4) @(negedge clk);
    chk(!ref_div && !fb_div && !fout, "R1 in reset", {ref_div, fb_div, fout}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(!ref_div && !fb_div && !fout && !test_out, "R1 after reset",
        {ref_div, fb_div, fout, test_out}, 0);
  endtask

  task automatic t_prescale();
    int n;
    ref_edge = 1;
    gap(0, 100, n); gap(0, 100, n);
    chk(n == 16, "R2 every-cycle strobe", n, 16);
    ref_edge = 0;
    gap(0, 80, n);
    chk(n == 80, "R2 hold without strobe", n, 80);
    fork
      begin
        for (int i = 0; i < 200; i++) begin
          @(negedge clk); ref_edge = ~ref_edge;
        end
      end
      begin
        int g;
        gap(0, 100, g); gap(0, 100, g);
        chk(g == 32, "R2 alternate strobe", g, 32);
      end
    join
    ref_edge = 0;
  endtask

  task automatic t_feedback();
    int n;
    vco_edge = 1; test_sel = 3'b011; m_cfg = 9'd100;
    gap(1, 1000, n); gap(1, 1000, n);
    chk(n == 200, "R3 M=100", n, 200);
    m_cfg = 9'd150;
    gap(1, 1000, n); gap(1, 1000, n);
    chk(n == 300, "R3 M=150", n, 300);
  endtask

  task automatic t_m_update();
    int n;
    m_cfg = 9'd100;
    gap(1, 1000, n); gap(1, 1000, n);
    repeat (50) @(negedge clk);
    m_cfg = 9'd120;
    gap(1, 1000, n);
    chk(n == 150, "R6 current interval keeps old M", n, 150);
    gap(1, 1000, n);
    chk(n == 240, "R6 new M from next count", n, 240);
  endtask

  task automatic t_ndiv();
    int n, h, l;
    logic [1:0] codes[4] = '{2'b00, 2'b01, 2'b10, 2'b11};
    int         ratio[4] = '{2, 4, 8, 1};
    vco_edge = 1;
    for (int i = 0; i < 4; i++) begin
      n_cfg = codes[i];
      repeat (20) @(negedge clk);
      gap(2, 50, n);
      gap(2, 50, h);
      gap(2, 50, l);
      chk(h == ratio[i], "R4 N mapping", h, ratio[i]);
      chk(h == l, "R5 equal high/low", h, l);
    end
  endtask

  task automatic t_n_update();
    int n;
    n_cfg = 2'b10;
    repeat (20) @(negedge clk);
    gap(2, 50, n);
    repeat (3) @(negedge clk);
    n_cfg = 2'b01;
    gap(2, 50, n);
    chk(n == 5, "R7 current half keeps old N", n, 5);
    gap(2, 50, n);
    chk(n == 4, "R7 new N from next count", n, 4);
  endtask

  task automatic t_oe();
    int n;
    n_cfg = 2'b00; oe = 0;
    @(negedge clk);
    gap(2, 60, n);
    chk(n == 60 && fout == 0, "R8 gated low", n, 60);
    oe = 1;
    gap(2, 50, n); gap(2, 50, n);
    chk(n == 2, "R8 resumes at N", n, 2);
  endtask

  task automatic t_mux_static();
    test_sel = 3'b000; sr_out = 1; #1;
    chk(test_out == 1, "R9 shift out high", test_out, 1);
    sr_out = 0; #1;
    chk(test_out == 0, "R9 shift out low", test_out, 0);
    test_sel = 3'b001; #1;
    chk(test_out == 1, "R9 const high", test_out, 1);
    test_sel = 3'b101; #1;
    chk(test_out == 0, "R9 const low", test_out, 0);
    @(negedge clk);
  endtask

  task automatic t_mux_clocks();
    int n;
    ref_edge = 1; vco_edge = 1; m_cfg = 9'd100; n_cfg = 2'b01;
    test_sel = 3'b010;
    gap(3, 100, n); gap(3, 100, n);
    chk(n == 16, "R10 ref view", n, 16);
    test_sel = 3'b011;
    gap(3, 1000, n); gap(3, 1000, n);
    chk(n == 200, "R10 feedback view", n, 200);
    test_sel = 3'b100;
    gap(3, 100, n); gap(3, 100, n);
    chk(n == 4, "R10 output view", n, 4);
    ref_edge = 0;
  endtask

  task automatic t_serial_fb();
    int n;
    test_sel = 3'b110; vco_edge = 1; sclk_edge = 0; m_cfg = 9'd100;
    gap(3, 500, n);
    chk(n == 500, "R11 vco ignored", n, 500);
    sclk_edge = 1;
    gap(3, 1000, n); gap(3, 1000, n);
    chk(n == 200, "R11 serial-clocked M", n, 200);
    chk(test_out == fb_div, "R11 test shows feedback", test_out, fb_div);
    sclk_edge = 0;
  endtask

  task automatic t_quarter();
    int n;
    test_sel = 3'b111; vco_edge = 1;
    n_cfg = 2'b00;
    repeat (40) @(negedge clk);
    gap(3, 100, n); gap(3, 100, n);
    chk(n == 8, "R12 quarter N=2", n, 8);
    n_cfg = 2'b11;
    repeat (40) @(negedge clk);
    gap(3, 100, n); gap(3, 100, n);
    chk(n == 4, "R12 quarter N=1", n, 4);
  endtask

  initial begin
    t_reset();
    t_prescale();
    t_feedback();
    t_m_update();
    t_ndiv();
    t_n_update();
    t_oe();
    t_mux_static();
    t_mux_clocks();
    t_serial_fb();
    t_quarter();
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule